// File: doc/BRIEF.md
# Cache Repair Fuse Loader

This block runs once after each power-on or chip reset. It reads a fixed-size repair image from an external serial flash over a four-wire SPI link (mode 0). It keeps the image in on-die hold registers and drives redundancy steering and unit de-feature controls from them. Data-array repair entries each carry a row replacement and a column replacement. Tag-array repair entries carry a column replacement only. One disable bit per cache slice and one per core turn into clock-gate requests, each followed by a power shut-off request.

The read is one SPI read command followed by the image. The image begins with a 16-bit signature. If the signature is wrong, every control stays in its safe state (no repair, every unit enabled) and an error flag is raised. `load_done` marks the end of loading, and reset release of the cache and cores must wait for it. Once loaded, the controls cannot change until the next reset. All pins are plain level signals. No stream handshake is involved, because the block masters the serial link and sets its pace itself.

Image layout, sent MSB first, with the first bit received being the most significant: signature[15:0], slice disables (N_SLICE bits, top bit = highest slice), core disables (N_CORE bits, same order), N_DREP data entries (entry 0 first, each {row_valid, row_idx[ROW_W], col_valid, col_idx[COL_W]}), N_TREP tag entries (entry 0 first, each {col_valid, col_idx[COL_W]}), and zero padding up to a whole byte. With the defaults the image is 80 bits.

Top module: `repair_fuse_loader`

## Requirements
- R1: After reset is released, spi_cs_n goes low and 32 bits are sent on spi_mosi MSB first, one per SCK rising edge: 8'h03 and then the 24-bit START_ADDR. SCK is low whenever spi_cs_n is high.
- R2: After the command, exactly IMG_BITS further SCK cycles occur, and spi_miso is sampled in each of them. With the defaults this gives 112 SCK rising edges in total.
- R3: load_done is low during reset and until the last image bit has been taken and spi_cs_n is high again. Until then every repair enable and every request output is 0. Once high, load_done stays high until reset.
- R4: With a good signature, port slot d of dat_row_en, dat_row_idx, dat_col_en and dat_col_idx (bits [d*W +: W]) carries the fields of data entry d.
- R5: With a good signature, tag_col_en[t] and tag_col_idx[t*COL_W +: COL_W] carry tag entry t. The tag entries have no row fields.
- R6: Starting one cycle after load_done rises, slice_cg_req[i] equals slice disable bit i and core_cg_req[i] equals core disable bit i.
- R7: A shut-off request rises exactly one cycle after its clock-gate request and is never high while that clock-gate request is low.
- R8: If the signature differs from SIG, sig_err is 1 together with load_done, and every repair enable, index and request is 0.
- R9: After load_done, the serial link stays idle (spi_cs_n high, SCK low). Toggling spi_miso then changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; SCK runs at half this rate |
| rst_n | input | 1 | Asynchronous active-low reset; restarts loading |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Command/address bit to flash |
| spi_miso | input | 1 | Image bit from flash |
| load_done | output | 1 | Image fully loaded; gates downstream reset release |
| sig_err | output | 1 | Image signature mismatch |
| dat_row_en | output | N_DREP | Data-array row replacement enables |
| dat_row_idx | output | N_DREP*ROW_W | Data-array replaced row indices |
| dat_col_en | output | N_DREP | Data-array column replacement enables |
| dat_col_idx | output | N_DREP*COL_W | Data-array replaced column indices |
| tag_col_en | output | N_TREP | Tag-array column replacement enables |
| tag_col_idx | output | N_TREP*COL_W | Tag-array replaced column indices |
| slice_cg_req | output | N_SLICE | Per-slice clock-gate request |
| slice_so_req | output | N_SLICE | Per-slice power shut-off request |
| core_cg_req | output | N_CORE | Per-core clock-gate request |
| core_so_req | output | N_CORE | Per-core power shut-off request |

## Verification
The properties assume that rst_n is the only event that restarts a load. They place no condition on spi_miso, so they must hold for any bit pattern the flash returns, including garbage after loading. The bench's flash model changes spi_miso only on SCK falling edges, as mode 0 requires. It releases reset only after a full clock cycle, and it deliberately toggles spi_miso after load_done to show that this input is then ignored.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int         CMD_BITS = 32;
  localparam int         SIG_BITS = 16;
  localparam logic [7:0] RD_OP    = 8'h03;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_LATCH, ST_DONE} seq_st_e;
endpackage

// File: rtl/spi_read_seq.sv
module spi_read_seq #(
  parameter int          IMG_BITS   = 80,
  parameter logic [23:0] START_ADDR = 24'h000100
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                sck,
  output logic                cs_n,
  output logic                mosi,
  input  logic                miso,
  output logic [IMG_BITS-1:0] img,
  output logic                img_vld
);
  import fuse_pkg::*;

  localparam int TOTAL = CMD_BITS + IMG_BITS;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] CMD_END = CW'(CMD_BITS);
  localparam logic [CW-1:0] LAST    = CW'(TOTAL - 1);

  seq_st_e              st;
  logic [CW-1:0]        bcnt;
  logic [CMD_BITS-1:0]  cmd_sr;
  logic [IMG_BITS-1:0]  sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bcnt   <= '0;
      cmd_sr <= '0;
      sr     <= '0;
      sck    <= 1'b0;
      cs_n   <= 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          cs_n   <= 1'b0;
          cmd_sr <= {RD_OP, START_ADDR};
          bcnt   <= '0;
          st     <= ST_XFER;
        end
        ST_XFER: begin
          if (!sck) begin
            sck <= 1'b1;
          end else begin
            sck    <= 1'b0;
            cmd_sr <= {cmd_sr[CMD_BITS-2:0], 1'b0};
            if (bcnt >= CMD_END) sr <= {sr[IMG_BITS-2:0], miso};
            if (bcnt == LAST) st <= ST_LATCH;
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_LATCH: begin
          cs_n <= 1'b1;
          st   <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  assign mosi    = cmd_sr[CMD_BITS-1];
  assign img     = sr;
  assign img_vld = (st == ST_LATCH);
endmodule

// File: rtl/fuse_hold.sv
module fuse_hold #(
  parameter int          IMG_BITS = 80,
  parameter int          N_SLICE  = 8,
  parameter int          N_CORE   = 8,
  parameter int          N_DREP   = 4,
  parameter int          N_TREP   = 2,
  parameter int          ROW_W    = 5,
  parameter int          COL_W    = 3,
  parameter logic [15:0] SIG      = 16'hA5C3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IMG_BITS-1:0]       img,
  input  logic                      img_vld,
  output logic                      loaded,
  output logic                      sig_err,
  output logic [N_SLICE-1:0]        slice_dis,
  output logic [N_CORE-1:0]         core_dis,
  output logic [N_DREP-1:0]         drow_en,
  output logic [N_DREP*ROW_W-1:0]   drow_idx,
  output logic [N_DREP-1:0]         dcol_en,
  output logic [N_DREP*COL_W-1:0]   dcol_idx,
  output logic [N_TREP-1:0]         tcol_en,
  output logic [N_TREP*COL_W-1:0]   tcol_idx
);
  import fuse_pkg::*;

  localparam int DE    = 2 + ROW_W + COL_W;
  localparam int TE    = 1 + COL_W;
  localparam int RAW   = SIG_BITS + N_SLICE + N_CORE + N_DREP*DE + N_TREP*TE;
  localparam int PAD   = IMG_BITS - RAW;
  localparam int TBASE = PAD;
  localparam int DBASE = TBASE + N_TREP*TE;
  localparam int CBASE = DBASE + N_DREP*DE;
  localparam int SBASE = CBASE + N_CORE;
  localparam int GBASE = SBASE + N_SLICE;

  logic [N_DREP-1:0]       nx_rowen, nx_colen;
  logic [N_DREP*ROW_W-1:0] nx_rowidx;
  logic [N_DREP*COL_W-1:0] nx_colidx;
  logic [N_TREP-1:0]       nx_ten;
  logic [N_TREP*COL_W-1:0] nx_tidx;
  logic                    sig_ok;

  for (genvar d = 0; d < N_DREP; d++) begin : g_dent
    localparam int B = DBASE + (N_DREP-1-d)*DE;
    assign nx_rowen[d]                 = img[B+DE-1];
    assign nx_rowidx[d*ROW_W +: ROW_W] = img[B+COL_W+1 +: ROW_W];
    assign nx_colen[d]                 = img[B+COL_W];
    assign nx_colidx[d*COL_W +: COL_W] = img[B +: COL_W];
  end

  for (genvar t = 0; t < N_TREP; t++) begin : g_tent
    localparam int B = TBASE + (N_TREP-1-t)*TE;
    assign nx_ten[t]                 = img[B+COL_W];
    assign nx_tidx[t*COL_W +: COL_W] = img[B +: COL_W];
  end

  assign sig_ok = (img[GBASE +: SIG_BITS] == SIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded    <= 1'b0;
      sig_err   <= 1'b0;
      slice_dis <= '0;
      core_dis  <= '0;
      drow_en   <= '0;
      drow_idx  <= '0;
      dcol_en   <= '0;
      dcol_idx  <= '0;
      tcol_en   <= '0;
      tcol_idx  <= '0;
    end else if (img_vld && !loaded) begin
      loaded  <= 1'b1;
      sig_err <= !sig_ok;
      if (sig_ok) begin
        slice_dis <= img[SBASE +: N_SLICE];
        core_dis  <= img[CBASE +: N_CORE];
        drow_en   <= nx_rowen;
        drow_idx  <= nx_rowidx;
        dcol_en   <= nx_colen;
        dcol_idx  <= nx_colidx;
        tcol_en   <= nx_ten;
        tcol_idx  <= nx_tidx;
      end
    end
  end
endmodule

// File: rtl/unit_pwr_ctl.sv
module unit_pwr_ctl #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         armed,
  input  logic [N-1:0] dis,
  output logic [N-1:0] cg_req,
  output logic [N-1:0] so_req
);
  for (genvar i = 0; i < N; i++) begin : g_unit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cg_req[i] <= 1'b0;
        so_req[i] <= 1'b0;
      end else begin
        cg_req[i] <= armed & dis[i];
        so_req[i] <= cg_req[i];
      end
    end
  end
endmodule

// File: rtl/repair_fuse_loader.sv
module repair_fuse_loader #(
  parameter int          N_SLICE    = 8,
  parameter int          N_CORE     = 8,
  parameter int          N_DREP     = 4,
  parameter int          N_TREP     = 2,
  parameter int          ROW_W      = 5,
  parameter int          COL_W      = 3,
  parameter logic [15:0] SIG        = 16'hA5C3,
  parameter logic [23:0] START_ADDR = 24'h000100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    spi_sck,
  output logic                    spi_cs_n,
  output logic                    spi_mosi,
  input  logic                    spi_miso,
  output logic                    load_done,
  output logic                    sig_err,
  output logic [N_DREP-1:0]       dat_row_en,
  output logic [N_DREP*ROW_W-1:0] dat_row_idx,
  output logic [N_DREP-1:0]       dat_col_en,
  output logic [N_DREP*COL_W-1:0] dat_col_idx,
  output logic [N_TREP-1:0]       tag_col_en,
  output logic [N_TREP*COL_W-1:0] tag_col_idx,
  output logic [N_SLICE-1:0]      slice_cg_req,
  output logic [N_SLICE-1:0]      slice_so_req,
  output logic [N_CORE-1:0]       core_cg_req,
  output logic [N_CORE-1:0]       core_so_req
);
  import fuse_pkg::*;

  localparam int RAW      = SIG_BITS + N_SLICE + N_CORE
                          + N_DREP*(2+ROW_W+COL_W) + N_TREP*(1+COL_W);
  localparam int IMG_BITS = ((RAW + 7) / 8) * 8;

  logic [IMG_BITS-1:0] img;
  logic                img_vld;
  logic [N_SLICE-1:0]  slice_dis;
  logic [N_CORE-1:0]   core_dis;

  spi_read_seq #(.IMG_BITS(IMG_BITS), .START_ADDR(START_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .miso(spi_miso), .img(img), .img_vld(img_vld)
  );

  fuse_hold #(
    .IMG_BITS(IMG_BITS), .N_SLICE(N_SLICE), .N_CORE(N_CORE), .N_DREP(N_DREP),
    .N_TREP(N_TREP), .ROW_W(ROW_W), .COL_W(COL_W), .SIG(SIG)
  ) u_hold (
    .clk(clk), .rst_n(rst_n), .img(img), .img_vld(img_vld),
    .loaded(load_done), .sig_err(sig_err),
    .slice_dis(slice_dis), .core_dis(core_dis),
    .drow_en(dat_row_en), .drow_idx(dat_row_idx),
    .dcol_en(dat_col_en), .dcol_idx(dat_col_idx),
    .tcol_en(tag_col_en), .tcol_idx(tag_col_idx)
  );

  unit_pwr_ctl #(.N(N_SLICE)) u_slice_pwr (
    .clk(clk), .rst_n(rst_n), .armed(load_done), .dis(slice_dis),
    .cg_req(slice_cg_req), .so_req(slice_so_req)
  );

  unit_pwr_ctl #(.N(N_CORE)) u_core_pwr (
    .clk(clk), .rst_n(rst_n), .armed(load_done), .dis(core_dis),
    .cg_req(core_cg_req), .so_req(core_so_req)
  );
endmodule

// File: rtl/fuse_loader_chk.sv
module fuse_loader_chk #(
  parameter int N_SLICE = 8,
  parameter int N_CORE  = 8,
  parameter int N_DREP  = 4,
  parameter int N_TREP  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               spi_sck,
  input logic               spi_cs_n,
  input logic               load_done,
  input logic               sig_err,
  input logic [N_DREP-1:0]  dat_row_en,
  input logic [N_DREP-1:0]  dat_col_en,
  input logic [N_TREP-1:0]  tag_col_en,
  input logic [N_SLICE-1:0] slice_cg_req,
  input logic [N_SLICE-1:0] slice_so_req,
  input logic [N_CORE-1:0]  core_cg_req,
  input logic [N_CORE-1:0]  core_so_req
);
  a_r1_sck_framed: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);

  a_r3_quiet_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> (dat_row_en == '0 && dat_col_en == '0 && tag_col_en == '0 &&
                    slice_cg_req == '0 && core_cg_req == '0 && !sig_err));

  a_r7_so_needs_cg: assert property (@(posedge clk) disable iff (!rst_n)
    ((slice_so_req & ~slice_cg_req) == '0) && ((core_so_req & ~core_cg_req) == '0));

  a_r7_so_lags_cg: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> (slice_so_req == $past(slice_cg_req) &&
                   core_so_req == $past(core_cg_req)));

  a_r8_bad_sig_blank: assert property (@(posedge clk) disable iff (!rst_n)
    sig_err |-> (load_done && dat_row_en == '0 && dat_col_en == '0 &&
                 tag_col_en == '0 && slice_cg_req == '0 && core_cg_req == '0));

  a_r9_link_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (spi_cs_n && !spi_sck));
endmodule

bind repair_fuse_loader fuse_loader_chk #(
  .N_SLICE(N_SLICE), .N_CORE(N_CORE), .N_DREP(N_DREP), .N_TREP(N_TREP)
) u_chk (.*);

// File: tb/sim_repair_fuse_loader.sv
module sim_repair_fuse_loader;
  localparam int          CLK_PER = 10;
  localparam int          NS = 8, NC = 8, ND = 4, NT = 2, RW = 5, CWD = 3;
  localparam logic [15:0] SIGV  = 16'hA5C3;
  localparam logic [23:0] ADDR  = 24'h000100;
  localparam int          IMGB  = 80;
  localparam int          TOTAL = 32 + IMGB;

  logic clk = 1'b0, rst_n = 1'b0, spi_miso = 1'b0;
  logic spi_sck, spi_cs_n, spi_mosi, load_done, sig_err;
  logic [ND-1:0] dat_row_en, dat_col_en;
  logic [ND*RW-1:0] dat_row_idx;
  logic [ND*CWD-1:0] dat_col_idx;
  logic [NT-1:0] tag_col_en;
  logic [NT*CWD-1:0] tag_col_idx;
  logic [NS-1:0] slice_cg_req, slice_so_req;
  logic [NC-1:0] core_cg_req, core_so_req;

  always #(CLK_PER/2) clk = ~clk;

  repair_fuse_loader u0 (.*);

  int n_chk = 0, n_err = 0;
  bit ended = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model, SPI mode 0
  logic [IMGB-1:0] img_v;
  logic [31:0]     cmd_cap;
  int              rcnt;

  always @(posedge spi_sck) begin
    if (rcnt < 32) cmd_cap = {cmd_cap[30:0], spi_mosi};
    rcnt++;
  end
  always @(negedge spi_sck) begin
    if (rcnt >= 32 && rcnt < TOTAL) spi_miso = img_v[IMGB-1-(rcnt-32)];
  end

  // case fields
  logic [15:0]    c_sig;
  logic [NS-1:0]  c_slice;
  logic [NC-1:0]  c_core;
  logic [ND-1:0]  c_rv, c_cv;
  logic [RW-1:0]  c_row [ND];
  logic [CWD-1:0] c_col [ND];
  logic [NT-1:0]  c_tv;
  logic [CWD-1:0] c_tcol [NT];
  logic [31:0]    lfsr = 32'h1234_5678;
  int             ptr;

  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic put(logic [31:0] v, int w);
    for (int b = w-1; b >= 0; b--) begin
      img_v[ptr] = v[b];
      ptr--;
    end
  endtask

  task automatic build();
    img_v = '0; ptr = IMGB-1;
    put(32'(c_sig), 16); put(32'(c_slice), NS); put(32'(c_core), NC);
    for (int d = 0; d < ND; d++) begin
      put(32'(c_rv[d]), 1); put(32'(c_row[d]), RW);
      put(32'(c_cv[d]), 1); put(32'(c_col[d]), CWD);
    end
    for (int t = 0; t < NT; t++) begin
      put(32'(c_tv[t]), 1); put(32'(c_tcol[t]), CWD);
    end
  endtask

  task automatic run_case(int c);
    logic ok;
    logic [ND*RW-1:0]  e_ridx;
    logic [ND*CWD-1:0] e_cidx;
    logic [NT*CWD-1:0] e_tidx;
    logic [63:0] snap;
    int waitc;
    lfsr = nxt(lfsr);
    c_slice = (c < 8) ? NS'(1 << c) : lfsr[7:0];
    c_core  = (c % 2 == 0) ? ~c_slice : lfsr[15:8];
    c_rv = lfsr[19:16]; c_cv = lfsr[23:20]; c_tv = lfsr[25:24];
    for (int d = 0; d < ND; d++) begin
      lfsr = nxt(lfsr);
      c_row[d] = lfsr[RW-1:0]; c_col[d] = lfsr[10:8];
    end
    for (int t = 0; t < NT; t++) begin
      lfsr = nxt(lfsr);
      c_tcol[t] = lfsr[2:0];
    end
    c_sig = (c >= 8) ? (SIGV ^ (16'h1 << c)) : SIGV;
    ok = (c_sig == SIGV);
    build();

    @(negedge clk);
    rst_n = 0; rcnt = 0; cmd_cap = '0; spi_miso = 0;
    repeat (3) @(negedge clk);
    chk("R3 done low in reset", 64'(load_done), 0);
    chk("R1 cs high in reset", 64'(spi_cs_n), 1);
    chk("R3 no request in reset", 64'({slice_cg_req, core_cg_req, dat_row_en}), 0);
    rst_n = 1;
    waitc = 0;
    while (!load_done && waitc < 1000) begin
      @(negedge clk); waitc++;
    end
    chk("R2 sck rising edges", 64'(rcnt), 64'(TOTAL));
    chk("R1 command word", 64'(cmd_cap), 64'({8'h03, ADDR}));
    chk("R9 link idle at done", 64'({spi_cs_n, spi_sck}), 64'(2'b10));
    chk("R8 sig_err", 64'(sig_err), 64'(!ok));
    chk("R6 cg not yet", 64'({slice_cg_req, core_cg_req}), 0);

    for (int d = 0; d < ND; d++) begin
      e_ridx[d*RW +: RW]   = ok ? c_row[d] : '0;
      e_cidx[d*CWD +: CWD] = ok ? c_col[d] : '0;
    end
    for (int t = 0; t < NT; t++) e_tidx[t*CWD +: CWD] = ok ? c_tcol[t] : '0;
    chk("R4 row enables", 64'(dat_row_en), 64'(ok ? c_rv : '0));
    chk("R4 row indices", 64'(dat_row_idx), 64'(e_ridx));
    chk("R4 col enables", 64'(dat_col_en), 64'(ok ? c_cv : '0));
    chk("R4 col indices", 64'(dat_col_idx), 64'(e_cidx));
    chk("R5 tag col enables", 64'(tag_col_en), 64'(ok ? c_tv : '0));
    chk("R5 tag col indices", 64'(tag_col_idx), 64'(e_tidx));

    @(negedge clk);
    chk("R6 slice cg", 64'(slice_cg_req), 64'(ok ? c_slice : '0));
    chk("R6 core cg", 64'(core_cg_req), 64'(ok ? c_core : '0));
    chk("R7 so lags", 64'({slice_so_req, core_so_req}), 0);
    @(negedge clk);
    chk("R7 slice so", 64'(slice_so_req), 64'(ok ? c_slice : '0));
    chk("R7 core so", 64'(core_so_req), 64'(ok ? c_core : '0));

    snap = {dat_row_en, dat_col_en, tag_col_en, slice_cg_req, core_cg_req,
            dat_col_idx, tag_col_idx, sig_err};
    for (int k = 0; k < 40; k++) begin
      spi_miso = ~spi_miso;
      @(negedge clk);
    end
    chk("R9 outputs frozen", {dat_row_en, dat_col_en, tag_col_en, slice_cg_req,
        core_cg_req, dat_col_idx, tag_col_idx, sig_err}, snap);
    chk("R9 row idx frozen", 64'(dat_row_idx), 64'(e_ridx));
    chk("R9 no extra sck", 64'(rcnt), 64'(TOTAL));
    chk("R3 done held", 64'(load_done), 1);
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!ended) begin
      ended = 1;
      n_err++;
      $display("FAIL R3 watchdog expired: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 10; c++) run_case(c);
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule